// File: doc/BRIEF.md
# Overlapping Serial Pattern Detector

This block watches a one-bit serial stream and reports every occurrence of the seven-bit value 1010111, whose least significant bit travels first. On the wire the expected order is therefore 1,1,1,0,1,0,1. A match may start at any bit, and matches may share bits: the final 1 of one occurrence can also be the first bit of the next.

One shared tracker holds how many leading pattern bits the recent history matches, from 0 to 6. When a bit breaks the run, the tracker does not go back to zero. It keeps the longest leading part of the pattern that still ends the history. Two flags come from the tracker. `hit_now` is combinational: it rises in the same cycle as the completing bit. `hit_reg` is a flop: it is high during the cycle after that bit.

The input is a stream without back-pressure. A bit is taken on every rising clock edge where `bit_vld` is high. There is no ready signal, so the source never has to wait. When `bit_vld` is low, the bit is ignored and the tracker holds its value.

Top module: `serial_pattern_detector`

## Requirements
- R1: While `rst` is high at a rising edge, the tracker returns to zero matched bits. `hit_reg` is low in the following cycle, and `hit_now` is low for as long as `rst` is high.
- R2: The detector fires on the wire order 1,1,1,0,1,0,1 (the value 1010111, bit 0 first). `hit_now` is high together with the seventh bit.
- R3: `hit_now` is combinational from the tracker and the present input. It is observable before the clock edge that takes the completing bit, and it is high only while that bit is presented with `bit_vld` high.
- R4: `hit_reg` is high for exactly the one cycle after each cycle in which `hit_now` was high at the clock edge, and it is low otherwise, whatever the value of `bit_vld` in that cycle.
- R5: After a complete match the tracker holds one matched bit, so overlapping matches are all reported. The stream 1110101110101 fires on its 7th and 13th bits.
- R6: A cycle with `bit_vld` low leaves the tracker unchanged and keeps `hit_now` low. A pattern split by such gaps is still detected when its last valid bit arrives.
- R7: On a mismatch the tracker falls back to the longest leading part of the pattern that ends the history, not to zero. The stream 11110101 fires on its 8th bit, and 11101110101 fires on its 11th bit.
- R8: Reset wins over a completing bit in the same cycle. No flag fires then or in the next cycle, and the next bits are matched from an empty history.
- R9: The flags never fire except where the last seven valid bits since reset form the pattern. This holds across a long mixed stream with gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | Qualifies `bit_in` in this cycle |
| bit_in | input | 1 | Serial data bit |
| hit_now | output | 1 | Combinational match flag, with the completing bit |
| hit_reg | output | 1 | Registered match flag, one cycle after the completing bit |

## Verification
The collision that matters here is between a completing bit and a synchronous reset in the same cycle. To provoke it, six matching bits are fed, and then the seventh is presented while `rst` is high. The check is that `hit_now` stays low in that cycle, that `hit_reg` stays low in the next, and that a fresh seven-bit match is needed afterwards. A second overlap places the registered flag of one match in a cycle that is either a gap or the first bit of the next occurrence. There `hit_reg` must still be high while the tracker holds or advances correctly.

// File: rtl/sd_pkg.sv
package sd_pkg;

  localparam int unsigned MAX_LEN = 32;

  // Tracker successor: given s matched leading bits and a new bit b, return
  // the longest k (< len) such that the first k pattern bits end the history.
  function automatic int unsigned step_depth(
    input logic [MAX_LEN-1:0] pat,
    input int unsigned        len,
    input int unsigned        s,
    input logic               b
  );
    int unsigned best;
    best = 0;
    for (int k = 1; k < MAX_LEN; k++) begin
      if ((k <= int'(s) + 1) && (k < int'(len))) begin
        logic ok;
        ok = (pat[5'(k - 1)] == b);
        for (int j = 0; j < MAX_LEN - 1; j++) begin
          if ((j < k - 1) && (pat[5'(j)] != pat[5'(int'(s) + 1 - k + j)])) begin
            ok = 1'b0;
          end
        end
        if (ok) begin
          best = k;
        end
      end
    end
    return best;
  endfunction

endpackage

// File: rtl/sd_progress.sv
module sd_progress #(
  parameter int unsigned          PAT_LEN = 7,
  parameter logic [PAT_LEN-1:0]   PATTERN = 7'b1010111,
  localparam int unsigned         DEPTH_W = $clog2(PAT_LEN)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_vld,
  input  logic               bit_in,
  output logic [DEPTH_W-1:0] depth_q
);

  logic [DEPTH_W-1:0] next_on0 [PAT_LEN];
  logic [DEPTH_W-1:0] next_on1 [PAT_LEN];
  logic [DEPTH_W-1:0] depth_d;

  // One row of successors per tracker value, folded at elaboration.
  for (genvar s = 0; s < PAT_LEN; s++) begin : g_row
    localparam int unsigned N0 =
      sd_pkg::step_depth(32'(PATTERN), PAT_LEN, s, 1'b0);
    localparam int unsigned N1 =
      sd_pkg::step_depth(32'(PATTERN), PAT_LEN, s, 1'b1);
    assign next_on0[s] = DEPTH_W'(N0);
    assign next_on1[s] = DEPTH_W'(N1);
  end

  always_comb begin
    depth_d = depth_q;
    if (bit_vld) begin
      depth_d = bit_in ? next_on1[depth_q] : next_on0[depth_q];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      depth_q <= '0;
    end else begin
      depth_q <= depth_d;
    end
  end

endmodule

// File: rtl/sd_mealy.sv
module sd_mealy #(
  parameter int unsigned        PAT_LEN = 7,
  parameter logic [PAT_LEN-1:0] PATTERN = 7'b1010111,
  localparam int unsigned       DEPTH_W = $clog2(PAT_LEN),
  localparam int unsigned       LAST    = PAT_LEN - 1
) (
  input  logic               rst,
  input  logic               bit_vld,
  input  logic               bit_in,
  input  logic [DEPTH_W-1:0] depth,
  output logic               hit
);

  assign hit = bit_vld & ~rst
             & (depth == DEPTH_W'(LAST))
             & (bit_in == PATTERN[LAST]);

endmodule

// File: rtl/sd_moore.sv
module sd_moore (
  input  logic clk,
  input  logic rst,
  input  logic done,
  output logic hit_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q <= 1'b0;
    end else begin
      hit_q <= done;
    end
  end

endmodule

// File: rtl/serial_pattern_detector.sv
module serial_pattern_detector #(
  parameter int unsigned        PAT_LEN = 7,
  parameter logic [PAT_LEN-1:0] PATTERN = 7'b1010111
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_vld,
  input  logic bit_in,
  output logic hit_now,
  output logic hit_reg
);

  localparam int unsigned DEPTH_W = $clog2(PAT_LEN);

  logic [DEPTH_W-1:0] depth_q;

  sd_progress #(.PAT_LEN(PAT_LEN), .PATTERN(PATTERN)) u_progress (
    .clk     (clk),
    .rst     (rst),
    .bit_vld (bit_vld),
    .bit_in  (bit_in),
    .depth_q (depth_q)
  );

  sd_mealy #(.PAT_LEN(PAT_LEN), .PATTERN(PATTERN)) u_mealy (
    .rst     (rst),
    .bit_vld (bit_vld),
    .bit_in  (bit_in),
    .depth   (depth_q),
    .hit     (hit_now)
  );

  sd_moore u_moore (
    .clk   (clk),
    .rst   (rst),
    .done  (hit_now),
    .hit_q (hit_reg)
  );

endmodule

// File: rtl/sd_checker.sv
module sd_checker #(
  parameter int unsigned        PAT_LEN = 7,
  parameter logic [PAT_LEN-1:0] PATTERN = 7'b1010111,
  localparam int unsigned       DEPTH_W = $clog2(PAT_LEN)
) (
  input logic               clk,
  input logic               rst,
  input logic               bit_vld,
  input logic               hit_now,
  input logic               hit_reg,
  input logic [DEPTH_W-1:0] depth
);

  localparam int unsigned REFOLD =
    sd_pkg::step_depth(32'(PATTERN), PAT_LEN, PAT_LEN - 1, PATTERN[PAT_LEN-1]);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (depth == '0) && !hit_reg);

  assert_depth_in_range_R2: assert property (@(posedge clk) disable iff (rst)
    int'(depth) < int'(PAT_LEN));

  assert_flag_needs_valid_R3: assert property (@(posedge clk) disable iff (rst)
    hit_now |-> bit_vld);

  assert_moore_follows_R4: assert property (@(posedge clk) disable iff (rst)
    hit_now |=> hit_reg);

  assert_moore_has_cause_R4: assert property (@(posedge clk) disable iff (rst)
    hit_reg |-> $past(hit_now));

  assert_refold_after_hit_R5: assert property (@(posedge clk) disable iff (rst)
    hit_now |=> (int'(depth) == int'(REFOLD)));

  assert_gap_holds_R6: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |=> $stable(depth));

  assert_gap_silent_R6: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |-> !hit_now);

endmodule

bind serial_pattern_detector sd_checker #(.PAT_LEN(PAT_LEN), .PATTERN(PATTERN)) u_sd_checker (
  .clk     (clk),
  .rst     (rst),
  .bit_vld (bit_vld),
  .hit_now (hit_now),
  .hit_reg (hit_reg),
  .depth   (depth_q)
);

// File: tb/serial_pattern_detector_bench.sv
module serial_pattern_detector_bench;

  localparam logic [6:0] PAT = 7'b1010111;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_vld = 1'b0;
  logic bit_in = 1'b0;
  logic hit_now;
  logic hit_reg;

  int errors = 0;
  int checks = 0;

  // Reference: last seven valid bits, newest at the top.
  logic [6:0]  hist = '0;
  int          nseen = 0;
  logic        exp_moore = 1'b0;
  logic [63:0] hit_mask;

  always #5 clk = ~clk;

  serial_pattern_detector u_serial_pattern_detector (
    .clk     (clk),
    .rst     (rst),
    .bit_vld (bit_vld),
    .bit_in  (bit_in),
    .hit_now (hit_now),
    .hit_reg (hit_reg)
  );

  task automatic check(input logic ok, input string req, input string what,
                       input logic got, input logic exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic step(input logic v, input logic b, input string req, output logic seen);
    logic exp_now;
    @(negedge clk);
    rst = 1'b0; bit_vld = v; bit_in = b;
    exp_now = v && (nseen >= 6) && ({b, hist[6:1]} == PAT);
    #2;
    check(hit_now === exp_now, req, "hit_now", hit_now, exp_now);
    check(hit_reg === exp_moore, "R4", "hit_reg", hit_reg, exp_moore);
    seen = hit_now;
    @(posedge clk); #1;
    if (v) begin
      hist = {b, hist[6:1]};
      if (nseen < 7) nseen++;
    end
    exp_moore = exp_now;
  endtask

  task automatic do_reset(input logic v, input logic b, input string req);
    @(negedge clk);
    rst = 1'b1; bit_vld = v; bit_in = b;
    #2;
    check(hit_now === 1'b0, req, "hit_now in reset", hit_now, 1'b0);
    @(posedge clk); #1;
    check(hit_reg === 1'b0, req, "hit_reg after reset", hit_reg, 1'b0);
    hist = '0; nseen = 0; exp_moore = 1'b0;
  endtask

  task automatic send_str(input string s, input string req);
    logic seen;
    hit_mask = '0;
    for (int i = 0; i < s.len(); i++) begin
      step(1'b1, s[i] == "1", req, seen);
      hit_mask[i] = seen;
    end
  endtask

  task automatic check_mask(input logic [63:0] exp, input string req);
    checks++;
    if (hit_mask !== exp) begin
      errors++;
      $display("FAIL %s hit positions: actual=%h expected=%h", req, hit_mask, exp);
    end
  endtask

  task automatic t_reset_state;
    do_reset(1'b0, 1'b0, "R1");
    do_reset(1'b1, 1'b1, "R1");
  endtask

  task automatic t_single_match;
    logic seen;
    do_reset(1'b0, 1'b0, "R1");
    send_str("1110101", "R2");
    check_mask(64'h40, "R2");
    step(1'b1, 1'b0, "R3", seen);          // hit_reg expected high here (R4)
    send_str("1010111", "R2");             // value order on the wire must not fire
    check_mask(64'h0, "R2");
  endtask

  task automatic t_overlap;
    do_reset(1'b0, 1'b0, "R1");
    send_str("1110101110101", "R5");
    check_mask(64'h1040, "R5");
  endtask

  task automatic t_fallback;
    do_reset(1'b0, 1'b0, "R1");
    send_str("11110101", "R7");
    check_mask(64'h80, "R7");
    do_reset(1'b0, 1'b0, "R1");
    send_str("11101110101", "R7");
    check_mask(64'h400, "R7");
  endtask

  task automatic t_gaps;
    logic seen;
    do_reset(1'b0, 1'b0, "R1");
    send_str("111010", "R6");
    step(1'b0, 1'b1, "R6", seen);
    check(seen === 1'b0, "R6", "gap with completing bit", seen, 1'b0);
    step(1'b0, 1'b0, "R6", seen);
    step(1'b1, 1'b1, "R6", seen);
    check(seen === 1'b1, "R6", "match across gaps", seen, 1'b1);
    step(1'b0, 1'b0, "R4", seen);          // registered flag during a gap
  endtask

  task automatic t_reset_collision;
    logic seen;
    do_reset(1'b0, 1'b0, "R1");
    send_str("111010", "R8");
    do_reset(1'b1, 1'b1, "R8");
    send_str("1110101", "R8");
    check_mask(64'h40, "R8");
    step(1'b1, 1'b1, "R8", seen);
  endtask

  task automatic t_random;
    logic [15:0] lfsr = 16'hACE1;
    logic seen;
    int hits = 0;
    do_reset(1'b0, 1'b0, "R1");
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[3:0] != 4'h0, lfsr[0] | lfsr[5], "R9", seen);
      if (seen) hits++;
    end
    checks++;
    if (hits == 0) begin
      errors++;
      $display("FAIL R9 random stream hits: actual=%0d expected=nonzero", hits);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset_state();
    t_single_match();
    t_overlap();
    t_fallback();
    t_gaps();
    t_reset_collision();
    t_random();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule